// File: doc/BRIEF.md
# Host Interrupt Cause Collector with Coalescing

The block gathers single-cycle cause events from on-chip sources into a 32-bit primary status register and a 32-bit DMA-engine status register. Causes include receive and transmit DMA completion, hardware and firmware errors, a kill-switch toggle, over-temperature, wakeup and firmware-alive. DMA-engine channel causes also set a summary bit in the primary register. The primary status is masked by a host-written enable register and drives one level-sensitive interrupt line toward the host.

To cut the host's interrupt rate, assertion of the line is held back until a programmable window has elapsed since the first unmasked cause. The window is counted in 32 us ticks, which a prescaler derives from the core clock. A high-priority receive cause in the DMA register skips this window. The host reads and clears status through a simple single-cycle register bus. Status bits are write-one-to-clear.

Top module: `irq_coalesce_top`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: A pulse on `prim_evt_i[n]` sets primary status bit n for n in {31,29,28,27,26,25,7,6,3,1,0}. Other bit positions ignore events and read 0. The DMA register (offset 0x010) keeps only bits {31,30,17,16,1,0}.
- R3: A write to 0x008 or 0x010 clears each status bit written as 1 and leaves bits written as 0 unchanged.
- R4: When a cause event and a host clear hit the same bit in the same cycle, the bit ends up set.
- R5: `irq_o` is never high while (primary status AND enable mask at 0x00C) is zero. A masked cause does not raise it.
- R6: With a window value of 0, `irq_o` rises in the first cycle in which an unmasked bit is pending.
- R7: With window W>0, `irq_o` rises exactly W*32*CLK_MHZ cycles after the clock edge that made the first unmasked bit pending. It stays low before that.
- R8: Clearing all unmasked pending bits drops `irq_o` and rearms the timer. The next cause waits a full window.
- R9: A DMA event on bit 16 or 17 also sets primary bit 31. A DMA event on bit 0 or 1 also sets primary bit 27. A DMA event on bit 31 also sets primary bit 29.
- R10: While DMA status bit 30 is set and an unmasked primary bit is pending, `irq_o` is high regardless of the window.
- R11: Primary bit 28 accepts events only while the periodic control byte equals 0xFF. Any other value, including 0x00, blocks it.
- R12: Offset 0x004 reads back the window in bits [7:0] and the periodic control byte in bits [15:8]. Its upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 12 | Register byte address |
| we_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| prim_evt_i | input | 32 | Primary cause event pulses |
| dma_evt_i | input | 32 | DMA-engine cause event pulses |
| irq_o | output | 1 | Interrupt line to host |

## Verification
The hardest condition to reach from the ports is the exact expiry edge of the coalescing window. Reaching it needs a cause landing while the timer is idle and the prescaler is at zero. The bench overrides the clock-frequency parameter so that one tick is 32 cycles. It then samples `irq_o` one cycle before and at the computed expiry edge. Afterwards it clears the pending bit, raises a new cause and waits the full window again to show the timer was rearmed. The same-cycle set and clear case is reached by driving an event pulse and a clear write on one edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_COAL = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_STAT = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_MASK = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_DMA  = 12'h010;

  // primary cause positions
  localparam int unsigned B_RX_DMA   = 31;
  localparam int unsigned B_HW_ERR   = 29;
  localparam int unsigned B_PERIODIC = 28;
  localparam int unsigned B_TX_DMA   = 27;
  localparam int unsigned B_QPTR     = 26;
  localparam int unsigned B_FW_ERR   = 25;
  localparam int unsigned B_KILL     = 7;
  localparam int unsigned B_HOT      = 6;
  localparam int unsigned B_SW_RX    = 3;
  localparam int unsigned B_WAKE     = 1;
  localparam int unsigned B_ALIVE    = 0;

  // DMA-engine cause positions
  localparam int unsigned D_ERR   = 31;
  localparam int unsigned D_HIPRI = 30;
  localparam int unsigned D_RX1   = 17;
  localparam int unsigned D_RX0   = 16;
  localparam int unsigned D_TX1   = 1;
  localparam int unsigned D_TX0   = 0;

  localparam logic [DATA_W-1:0] PRIM_IMPL = 32'hBE0000CB;
  localparam logic [DATA_W-1:0] DMA_IMPL  = 32'hC0030003;

  localparam logic [7:0] PERIODIC_ON = 8'hFF;
endpackage

// File: rtl/cause_reg.sv
module cause_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  // set dominates clear so no event is dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= ((q & ~clr_i) | set_i) & IMPL;
  end

  assign q_o = q;
endmodule

// File: rtl/coal_timer.sv
module coal_timer #(
  parameter int unsigned CLK_MHZ = 100,
  parameter int unsigned WIN_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pending_i,
  input  logic [WIN_W-1:0] window_i,
  output logic             expired_o
);
  localparam int unsigned TICK_CYCLES = CLK_MHZ * 32;
  localparam int unsigned PRE_W = $clog2(TICK_CYCLES + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

  logic [PRE_W-1:0] pre_q;
  logic [WIN_W-1:0] ticks_q;
  logic             exp_q;
  logic [WIN_W:0]   ticks_nx;

  assign ticks_nx = {1'b0, ticks_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      ticks_q <= '0;
      exp_q   <= 1'b0;
    end else if (!pending_i) begin
      pre_q   <= '0;
      ticks_q <= '0;
      exp_q   <= 1'b0;
    end else if (!exp_q) begin
      if (pre_q == PRE_LAST) begin
        pre_q   <= '0;
        ticks_q <= ticks_nx[WIN_W-1:0];
        if (ticks_nx >= {1'b0, window_i}) exp_q <= 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign expired_o = exp_q;
endmodule

// File: rtl/irq_coalesce_top.sv
module irq_coalesce_top
  import irq_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 100,
  parameter int unsigned WIN_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] prim_evt_i,
  input  logic [DATA_W-1:0] dma_evt_i,
  output logic              irq_o
);
  logic [DATA_W-1:0] prim_q, dma_q, mask_q;
  logic [DATA_W-1:0] prim_set, prim_clr, dma_clr;
  logic [WIN_W-1:0]  win_q;
  logic [7:0]        per_q;
  logic              pending, expired, bypass;

  // register writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      win_q  <= '0;
      per_q  <= '0;
    end else if (we_i) begin
      if (addr_i == OFS_MASK) mask_q <= wdata_i;
      if (addr_i == OFS_COAL) begin
        win_q <= wdata_i[WIN_W-1:0];
        per_q <= wdata_i[15:8];
      end
    end
  end

  assign prim_clr = (we_i && addr_i == OFS_STAT) ? wdata_i : '0;
  assign dma_clr  = (we_i && addr_i == OFS_DMA)  ? wdata_i : '0;

  // primary set vector with DMA roll-up and periodic gate
  always_comb begin
    prim_set = prim_evt_i;
    prim_set[B_PERIODIC] = prim_evt_i[B_PERIODIC] && (per_q == PERIODIC_ON);
    prim_set[B_RX_DMA]   = prim_evt_i[B_RX_DMA] | dma_evt_i[D_RX0] | dma_evt_i[D_RX1];
    prim_set[B_TX_DMA]   = prim_evt_i[B_TX_DMA] | dma_evt_i[D_TX0] | dma_evt_i[D_TX1];
    prim_set[B_HW_ERR]   = prim_evt_i[B_HW_ERR] | dma_evt_i[D_ERR];
  end

  cause_reg #(.W(DATA_W), .IMPL(PRIM_IMPL)) u_prim (
    .clk_i, .rst_ni, .set_i(prim_set), .clr_i(prim_clr), .q_o(prim_q)
  );

  cause_reg #(.W(DATA_W), .IMPL(DMA_IMPL)) u_dma (
    .clk_i, .rst_ni, .set_i(dma_evt_i), .clr_i(dma_clr), .q_o(dma_q)
  );

  assign pending = |(prim_q & mask_q);
  assign bypass  = dma_q[D_HIPRI];

  coal_timer #(.CLK_MHZ(CLK_MHZ), .WIN_W(WIN_W)) u_timer (
    .clk_i, .rst_ni, .pending_i(pending), .window_i(win_q), .expired_o(expired)
  );

  assign irq_o = pending && (expired || bypass || win_q == '0);

  // read mux
  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_COAL: begin
        rdata_o[WIN_W-1:0] = win_q;
        rdata_o[15:8]      = per_q;
      end
      OFS_STAT: rdata_o = prim_q;
      OFS_MASK: rdata_o = mask_q;
      OFS_DMA:  rdata_o = dma_q;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_coalesce_chk.sv
module irq_coalesce_chk
  import irq_pkg::*;
#(
  parameter int unsigned WIN_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] prim_evt_i,
  input logic [DATA_W-1:0] dma_evt_i,
  input logic [DATA_W-1:0] stat_i,
  input logic [DATA_W-1:0] dma_i,
  input logic [DATA_W-1:0] mask_i,
  input logic [WIN_W-1:0]  win_i,
  input logic              irq_i
);
  // R5
  no_spurious_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_i & mask_i) == '0) |-> !irq_i);

  // R2
  unimpl_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_i & ~PRIM_IMPL) == '0) && ((dma_i & ~DMA_IMPL) == '0));

  // R4
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prim_evt_i[B_ALIVE] |=> stat_i[B_ALIVE]);

  // R9
  rx_rollup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_evt_i[D_RX0] || dma_evt_i[D_RX1]) |=> stat_i[B_RX_DMA]);

  // R10
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_i[D_HIPRI] && ((stat_i & mask_i) != '0)) |-> irq_i);

  // R6
  zero_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_i == '0 && ((stat_i & mask_i) != '0)) |-> irq_i);
endmodule

bind irq_coalesce_top irq_coalesce_chk #(.WIN_W(WIN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .prim_evt_i(prim_evt_i), .dma_evt_i(dma_evt_i),
  .stat_i(prim_q), .dma_i(dma_q), .mask_i(mask_q), .win_i(win_q), .irq_i(irq_o)
);

// File: tb/tb_irq_coalesce_top.sv
module tb_irq_coalesce_top;
  localparam int unsigned TICK = 32; // CLK_MHZ=1
  localparam int unsigned NVEC = 7;
  // {prim_evt, dma_evt, exp_prim, exp_dma}
  localparam logic [127:0] VEC [NVEC] = '{
    {32'h00000001, 32'h00000000, 32'h00000001, 32'h00000000},
    {32'hFFFFFFFF, 32'h00000000, 32'hAE0000CB, 32'h00000000},
    {32'h00000000, 32'h00010000, 32'h80000000, 32'h00010000},
    {32'h00000000, 32'h00000002, 32'h08000000, 32'h00000002},
    {32'h00000000, 32'h80000000, 32'h20000000, 32'h80000000},
    {32'h00000000, 32'hFFFFFFFF, 32'hA8000000, 32'hC0030003},
    {32'h00000300, 32'h00000000, 32'h00000000, 32'h00000000}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [31:0] prim_evt_i = '0;
  logic [31:0] dma_evt_i = '0;
  logic        irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  irq_coalesce_top #(.CLK_MHZ(1), .WIN_W(8)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic pulse(input logic [31:0] p, input logic [31:0] q);
    @(negedge clk_i);
    prim_evt_i = p; dma_evt_i = q;
    @(negedge clk_i);
    prim_evt_i = '0; dma_evt_i = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(12'h008, v); chk("R1 stat", v, 32'h0);
    rd(12'h010, v); chk("R1 dma", v, 32'h0);
    rd(12'h00C, v); chk("R1 mask", v, 32'h0);
    rd(12'h004, v); chk("R1 coal", v, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);

    // R2 R9 R11 table walk
    for (int i = 0; i < NVEC; i++) begin
      pulse(VEC[i][127:96], VEC[i][95:64]);
      rd(12'h008, v); chk("R2/R9 prim", v, VEC[i][63:32]);
      rd(12'h010, v); chk("R2/R9 dma", v, VEC[i][31:0]);
      wr(12'h008, 32'hFFFFFFFF);
      wr(12'h010, 32'hFFFFFFFF);
    end

    // R12 readback, R11 periodic enabled
    wr(12'h004, 32'hABCD_FF00);
    rd(12'h004, v); chk("R12 coal", v, 32'h0000FF00);
    pulse(32'h10000000, 32'h0);
    rd(12'h008, v); chk("R11 periodic on", v, 32'h10000000);
    wr(12'h004, 32'h0000_7F00);
    pulse(32'h10000000, 32'h0);
    rd(12'h008, v); chk("R11 ctrl 7F held", v, 32'h10000000);
    wr(12'h008, 32'h10000000);
    pulse(32'h10000000, 32'h0);
    rd(12'h008, v); chk("R11 periodic blocked", v, 32'h0);

    // R3 partial clear
    pulse(32'h00000003, 32'h0);
    wr(12'h008, 32'h00000002);
    rd(12'h008, v); chk("R3 w1c", v, 32'h00000001);
    wr(12'h008, 32'h00000000);
    rd(12'h008, v); chk("R3 zero write", v, 32'h00000001);

    // R4 set and clear on same edge
    @(negedge clk_i);
    prim_evt_i = 32'h00000001; addr_i = 12'h008; wdata_i = 32'h1; we_i = 1'b1;
    @(negedge clk_i);
    prim_evt_i = '0; we_i = 1'b0;
    rd(12'h008, v); chk("R4 set wins", v, 32'h00000001);
    wr(12'h008, 32'hFFFFFFFF);

    // R5 masked cause, R6 zero window
    wr(12'h004, 32'h0);
    wr(12'h00C, 32'h00000001);
    pulse(32'h00000002, 32'h0);
    chk("R5 masked", {31'b0, irq_o}, 32'h0);
    pulse(32'h00000001, 32'h0);
    chk("R6 immediate", {31'b0, irq_o}, 32'h1);
    wr(12'h008, 32'hFFFFFFFF);
    chk("R8 clear drops", {31'b0, irq_o}, 32'h0);

    // R7 window of 2 ticks
    wr(12'h004, 32'h00000002);
    @(negedge clk_i);
    prim_evt_i = 32'h1;
    @(negedge clk_i);
    prim_evt_i = '0;
    repeat (2 * TICK - 1) @(negedge clk_i);
    chk("R7 before expiry", {31'b0, irq_o}, 32'h0);
    @(negedge clk_i);
    chk("R7 at expiry", {31'b0, irq_o}, 32'h1);

    // R8 clear rearms full window
    wr(12'h008, 32'h1);
    chk("R8 cleared", {31'b0, irq_o}, 32'h0);
    @(negedge clk_i);
    prim_evt_i = 32'h1;
    @(negedge clk_i);
    prim_evt_i = '0;
    repeat (2 * TICK - 1) @(negedge clk_i);
    chk("R8 rearmed low", {31'b0, irq_o}, 32'h0);
    @(negedge clk_i);
    chk("R8 rearmed high", {31'b0, irq_o}, 32'h1);
    wr(12'h008, 32'hFFFFFFFF);

    // R10 bypass via DMA bit 30
    wr(12'h00C, 32'h80000000);
    pulse(32'h0, 32'h40010000);
    chk("R10 bypass", {31'b0, irq_o}, 32'h1);
    wr(12'h010, 32'h40000000);
    chk("R10 bypass gone", {31'b0, irq_o}, 32'h0);

    finish_run();
  end
endmodule